// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is a compact single-accumulator processor core. It owns a small word memory that holds program and data together. After reset the core sits idle. A loader port can fill the memory during this time, and a start pulse then begins execution at word 0. Each 16-bit instruction word carries its operation in the top four bits. The lower twelve bits carry either a memory address, a two-bit test condition, or nothing at all. Arithmetic always combines the accumulator with one memory word.

Every instruction passes through three one-cycle phases: fetch, decode and execute. During decode the operand word is read into a data register, so the execute phase never waits on memory. A halt instruction parks the core until the next reset. An operand-free instruction whose unused bits are not zero still executes, but it raises a sticky format-error flag. The accumulator is always visible on an output port.

Top module: `acc_core`

## Requirements
- R1: After reset, halted, fmt_err and acc_out are all 0, and the core stays idle until start is seen high. When start is accepted, execution begins at address 0.
- R2: Bits 15:12 hold the operation code and bits 11:0 hold the operand address. Code 1 copies M[addr] into the accumulator. Code 3 adds M[addr] to it and code 4 subtracts M[addr] from it, both modulo 2^16.
- R3: Code 2 writes the accumulator into M[addr]. Code 9 continues execution at addr.
- R4: Code 8 tests the accumulator as a signed value, using bits 11:10 as the test: 00 is negative, 01 is zero, 10 is positive, and 11 never passes. When the test passes, the next word is skipped.
- R5: Code 7 raises halted. From then until reset, the accumulator and program counter hold their values and start has no effect.
- R6: Codes 0, 5, 6 and 10 to 15 change nothing but the program counter.
- R7: fmt_err goes to 1 when a halt has nonzero bits 11:0, or when a code 8 has nonzero bits 9:0. The instruction still executes normally. The flag stays at 1 until reset.
- R8: A loader write (ld_en with ld_addr and ld_data) takes effect only while the core is idle. Such writes are ignored while the core is running or halted.
- R9: A loader write presented in the same cycle as the accepted start pulse is stored, and the first fetch sees it.
- R10: Each instruction takes exactly three cycles. A program of n instructions that ends in halt raises halted 3n cycles after the cycle in which start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 (only while idle) |
| ld_en | input | 1 | Loader write strobe |
| ld_addr | input | MEM_AW | Loader word address |
| ld_data | input | 16 | Loader write data |
| halted | output | 1 | Core has executed a halt |
| fmt_err | output | 1 | Sticky malformed-instruction flag |
| acc_out | output | 16 | Current accumulator value |

## Verification
A loader write and the start pulse can arrive in the same cycle, because the core is still idle on that edge. The bench first loads word 0 with a halt. In the start cycle it overwrites word 0 with a load of a known data word. The result is judged on acc_out: if the write landed, the accumulator holds the data word, and if it was dropped the accumulator stays 0. The opposite case is also tested. Writes attempted while the core runs, and while it is halted, must leave a data word unchanged, and a later program that reads that word back shows whether they did.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int INSTR_W = 16;
    localparam int OP_W    = 4;
    localparam int FIELD_W = INSTR_W - OP_W;
    localparam int COND_W  = 2;

    localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
    localparam logic [OP_W-1:0] OP_STORE = 4'd2;
    localparam logic [OP_W-1:0] OP_ADD   = 4'd3;
    localparam logic [OP_W-1:0] OP_SUB   = 4'd4;
    localparam logic [OP_W-1:0] OP_HALT  = 4'd7;
    localparam logic [OP_W-1:0] OP_SKIP  = 4'd8;
    localparam logic [OP_W-1:0] OP_JUMP  = 4'd9;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FETCH  = 3'd1,
        PH_DECODE = 3'd2,
        PH_EXEC   = 3'd3,
        PH_HALT   = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e               phase;
        logic [FIELD_W-1:0]   pc;
        logic [INSTR_W-1:0]   ir;
        logic [FIELD_W-1:0]   mar;
        logic [INSTR_W-1:0]   mbr;
        logic [INSTR_W-1:0]   acc;
        logic                 fmt_err;
    } core_state_t;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int AW = 6,
    parameter int W  = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/acc_decode.sv
module acc_decode
    import acc_core_pkg::*;
(
    input  logic [INSTR_W-1:0] ir,
    input  logic [INSTR_W-1:0] acc,
    output logic [OP_W-1:0]    op,
    output logic [FIELD_W-1:0] field,
    output logic               skip_take,
    output logic               fmt_bad
);
    localparam int PAD_W = FIELD_W - COND_W;

    logic [COND_W-1:0] cond;
    logic              acc_neg;
    logic              acc_zero;

    assign op       = ir[INSTR_W-1 -: OP_W];
    assign field    = ir[FIELD_W-1:0];
    assign cond     = ir[FIELD_W-1 -: COND_W];
    assign acc_neg  = acc[INSTR_W-1];
    assign acc_zero = (acc == '0);

    always_comb begin
        case (cond)
            2'd0:    skip_take = acc_neg;
            2'd1:    skip_take = acc_zero;
            2'd2:    skip_take = !acc_neg && !acc_zero;
            default: skip_take = 1'b0;
        endcase
    end

    always_comb begin
        fmt_bad = 1'b0;
        if (op == OP_HALT) begin
            fmt_bad = (field != '0);
        end else if (op == OP_SKIP) begin
            fmt_bad = (field[PAD_W-1:0] != '0);
        end
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               ld_en,
    input  logic [MEM_AW-1:0]  ld_addr,
    input  logic [INSTR_W-1:0] ld_data,
    output logic               halted,
    output logic               fmt_err,
    output logic [INSTR_W-1:0] acc_out
);
    core_state_t s_d, s_q;

    logic               mem_we;
    logic [MEM_AW-1:0]  mem_waddr;
    logic [INSTR_W-1:0] mem_wdata;
    logic [MEM_AW-1:0]  mem_raddr;
    logic [INSTR_W-1:0] mem_rdata;

    logic [OP_W-1:0]    dec_op;
    logic [FIELD_W-1:0] dec_field;
    logic               dec_skip;
    logic               dec_fmt_bad;

    acc_mem #(.AW(MEM_AW), .W(INSTR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    acc_decode u_dec (
        .ir        (s_q.ir),
        .acc       (s_q.acc),
        .op        (dec_op),
        .field     (dec_field),
        .skip_take (dec_skip),
        .fmt_bad   (dec_fmt_bad)
    );

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_waddr = ld_addr;
        mem_wdata = ld_data;
        mem_raddr = s_q.pc[MEM_AW-1:0];
        case (s_q.phase)
            PH_IDLE: begin
                mem_we = ld_en;
                if (start) begin
                    s_d.phase = PH_FETCH;
                    s_d.pc    = '0;
                end
            end
            PH_FETCH: begin
                s_d.ir    = mem_rdata;
                s_d.pc    = s_q.pc + 1'b1;
                s_d.phase = PH_DECODE;
            end
            PH_DECODE: begin
                mem_raddr = dec_field[MEM_AW-1:0];
                s_d.mar   = dec_field;
                s_d.mbr   = mem_rdata;
                s_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                s_d.phase   = PH_FETCH;
                s_d.fmt_err = s_q.fmt_err | dec_fmt_bad;
                case (dec_op)
                    OP_LOAD: s_d.acc = s_q.mbr;
                    OP_ADD:  s_d.acc = s_q.acc + s_q.mbr;
                    OP_SUB:  s_d.acc = s_q.acc - s_q.mbr;
                    OP_STORE: begin
                        mem_we    = 1'b1;
                        mem_waddr = s_q.mar[MEM_AW-1:0];
                        mem_wdata = s_q.acc;
                    end
                    OP_JUMP: s_d.pc = s_q.mar;
                    OP_SKIP: begin
                        if (dec_skip) begin
                            s_d.pc = s_q.pc + 1'b1;
                        end
                    end
                    OP_HALT: s_d.phase = PH_HALT;
                    default: ;
                endcase
            end
            PH_HALT: ;
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign halted  = (s_q.phase == PH_HALT);
    assign fmt_err = s_q.fmt_err;
    assign acc_out = s_q.acc;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_core_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               halted,
    input logic               fmt_err,
    input logic [INSTR_W-1:0] acc,
    input logic [FIELD_W-1:0] pc,
    input phase_e             phase,
    input logic               mem_we
);
    p_idle_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !start) |=> (phase == PH_IDLE));

    p_start_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start) |=> (phase == PH_FETCH && pc == '0));

    p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(acc) && $stable(pc)));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);

    p_no_load_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH || phase == PH_DECODE || phase == PH_HALT) |-> !mem_we);

    p_fetch_to_decode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |=> (phase == PH_DECODE));

    p_decode_to_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE) |=> (phase == PH_EXEC));

    p_exec_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC) |=> (phase == PH_FETCH || phase == PH_HALT));

endmodule

bind acc_core acc_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .halted  (halted),
    .fmt_err (fmt_err),
    .acc     (acc_out),
    .pc      (s_q.pc),
    .phase   (s_q.phase),
    .mem_we  (mem_we)
);

// File: tb/tb_acc_core.sv
module tb_acc_core;
    localparam int MEM_AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ld_en = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        halted;
    logic        fmt_err;
    logic [15:0] acc_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    acc_core #(.MEM_AW(MEM_AW)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .halted  (halted),
        .fmt_err (fmt_err),
        .acc_out (acc_out)
    );

    // vector: {word20, word21, opcode of second instruction, expected acc}
    localparam logic [51:0] VEC [0:7] = '{
        {16'h0005, 16'h0007, 4'h3, 16'h000C},
        {16'h0005, 16'h0007, 4'h4, 16'hFFFE},
        {16'h7FFF, 16'h0001, 4'h3, 16'h8000},
        {16'h0000, 16'h0000, 4'h4, 16'h0000},
        {16'hFFFF, 16'h0001, 4'h3, 16'h0000},
        {16'h1234, 16'hABCD, 4'h1, 16'hABCD},
        {16'h1234, 16'h5555, 4'h0, 16'h1234},
        {16'h1234, 16'h5555, 4'hF, 16'h1234}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        ld_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = MEM_AW'(a);
        ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run(output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!halted && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic skip_case(input logic [15:0] sk, input logic [15:0] v,
                             input logic [15:0] exp, input logic exp_err);
        int cyc;
        do_reset();
        wr(0, 16'h101E);
        wr(1, sk);
        wr(2, 16'h101F);
        wr(3, 16'h7000);
        wr(30, v);
        wr(31, 16'h1111);
        run(cyc);
        check(exp_err ? "R7 skip still executes" : "R4 skip", acc_out, exp);
        check(exp_err ? "R7 flag set" : "R4 no flag", {15'd0, fmt_err}, {15'd0, exp_err});
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] held;

        // R1 reset state and idling
        do_reset();
        check("R1 halted after reset", {15'd0, halted}, 16'd0);
        check("R1 fmt_err after reset", {15'd0, fmt_err}, 16'd0);
        check("R1 acc after reset", acc_out, 16'h0000);
        repeat (5) @(negedge clk);
        check("R1 idle without start", {15'd0, halted}, 16'd0);

        // table: LOAD 20; <op> 21; HALT
        for (int i = 0; i < 8; i++) begin
            logic [51:0] v;
            v = VEC[i];
            do_reset();
            wr(0, 16'h1014);
            wr(1, {v[19:16], 12'h015});
            wr(2, 16'h7000);
            wr(20, v[51:36]);
            wr(21, v[35:20]);
            run(cyc);
            if (v[19:16] == 4'h1 || v[19:16] == 4'h3 || v[19:16] == 4'h4)
                check("R2 arithmetic", acc_out, v[15:0]);
            else
                check("R6 no-op code", acc_out, v[15:0]);
            check("R10 three cycles per instruction", 16'(cyc), 16'd9);
            check("R7 no flag on clean program", {15'd0, fmt_err}, 16'd0);
        end

        // R3 store and jump
        do_reset();
        wr(0, 16'h101E); wr(1, 16'h301E); wr(2, 16'h201F); wr(3, 16'h1020);
        wr(4, 16'h9006); wr(5, 16'h1021); wr(6, 16'h301F); wr(7, 16'h7000);
        wr(30, 16'h0042); wr(32, 16'h0001); wr(33, 16'hDEAD);
        run(cyc);
        check("R3 store then jump", acc_out, 16'h0085);
        check("R10 cycles with jump", 16'(cyc), 16'd21);

        // R5 halt freezes, start ignored
        held = acc_out;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        check("R5 still halted", {15'd0, halted}, 16'd1);
        check("R5 acc frozen", acc_out, held);

        // R4 skip conditions
        skip_case(16'h8000, 16'h8000, 16'h8000, 1'b0);
        skip_case(16'h8000, 16'h0000, 16'h1111, 1'b0);
        skip_case(16'h8400, 16'h0000, 16'h0000, 1'b0);
        skip_case(16'h8400, 16'h0005, 16'h1111, 1'b0);
        skip_case(16'h8800, 16'h0005, 16'h0005, 1'b0);
        skip_case(16'h8800, 16'h0000, 16'h1111, 1'b0);
        skip_case(16'h8800, 16'hFFFF, 16'h1111, 1'b0);
        skip_case(16'h8C00, 16'h0000, 16'h1111, 1'b0);

        // R7 malformed skip and halt
        skip_case(16'h8401, 16'h0000, 16'h0000, 1'b1);
        do_reset();
        check("R7 reset clears flag", {15'd0, fmt_err}, 16'd0);
        wr(0, 16'h101E); wr(1, 16'h7001); wr(30, 16'h0003);
        run(cyc);
        check("R7 malformed halt still halts", {15'd0, halted}, 16'd1);
        check("R7 malformed halt acc", acc_out, 16'h0003);
        check("R7 malformed halt flag", {15'd0, fmt_err}, 16'd1);
        repeat (4) @(negedge clk);
        check("R7 flag sticky", {15'd0, fmt_err}, 16'd1);

        // R8 loader ignored while running and halted
        do_reset();
        wr(0, 16'h101E); wr(1, 16'h0000); wr(2, 16'h0000); wr(3, 16'h0000);
        wr(4, 16'h101E); wr(5, 16'h7000); wr(30, 16'h0007);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        ld_en = 1'b1; ld_addr = MEM_AW'(30); ld_data = 16'h0099;
        repeat (8) @(negedge clk);
        ld_en = 1'b0;
        cyc = 0;
        while (!halted && cyc < 1000) begin @(negedge clk); cyc++; end
        check("R8 write during run ignored", acc_out, 16'h0007);
        wr(30, 16'h0055);
        do_reset();
        wr(0, 16'h101E); wr(1, 16'h7000);
        run(cyc);
        check("R8 write while halted ignored", acc_out, 16'h0007);

        // R9 loader write in the start cycle
        do_reset();
        wr(0, 16'h7000); wr(1, 16'h7000); wr(30, 16'h4242);
        @(negedge clk);
        start = 1'b1; ld_en = 1'b1; ld_addr = '0; ld_data = 16'h101E;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        cyc = 0;
        while (!halted && cyc < 1000) begin @(negedge clk); cyc++; end
        check("R9 same-cycle write seen by fetch", acc_out, 16'h4242);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule